// File: doc/BRIEF.md
# CRC Configuration Stream Loader

This block fills the parameter registers of a programmable CRC engine from a stream of 4-bit nibbles. The stream carries a header and three fields of equal length. The header holds the CRC width, coded as the true width minus one, and the two reflection flags. The three fields are the polynomial, the starting value and the value XORed onto the result at the end. The block works out how many nibbles each field takes from the width, which arrives at the start of the same stream.

A controller raises `setup_en` and presents one nibble per clock. The first cycle in which `setup_en` is high after a cycle in which it was low starts a new sequence. When the last nibble of the final XOR field has been taken, `done` rises. After that, further nibbles are ignored until `setup_en` drops and rises again. The registers hold their values for the CRC datapath, which is outside this block.

Top module: `crc_cfg_loader`

## Requirements
- R1: After a synchronous reset, `width_code`, `refl_in`, `refl_out`, `poly`, `init_val`, `xor_out` and `done` all read zero.
- R2: A nibble taken while `setup_en` is high, with `setup_en` low in the cycle before, starts a sequence. On that edge the nibble is written to `width_code[3:0]`, while `width_code[5:4]`, both reflection flags, all three fields and `done` are cleared.
- R3: The second nibble of a sequence maps as follows: bit 3 goes to `width_code[5]`, bit 2 to `width_code[4]`, bit 1 to `refl_out` and bit 0 to `refl_in`.
- R4: Each field takes N nibbles, where N = floor((width_code + 4) / 4), capped at MAX_WIDTH/4. With the default MAX_WIDTH of 32, codes 0 to 3 give N = 1, code 15 gives N = 4, and codes 28 and above give N = 8.
- R5: After the header, the fields arrive in a fixed order: poly, then init_val, then xor_out. Within a field, the nibble at position k (counting from 0) lands in bits [4k+3:4k], so the least-significant nibble comes first. Field bits at 4N and above read zero.
- R6: `done` is low throughout a sequence. It is high from the edge that takes the last xor_out nibble, and it stays high until the next sequence start or a reset.
- R7: While `done` is high, nibbles presented with `setup_en` held high change no output.
- R8: Dropping `setup_en` for one or more cycles ends a sequence, complete or not. The next high cycle starts a new sequence as described in R2.
- R9: The stream f,3,5,0,0,8,f,f,f,f,f,f,f,f gives a width code of 15, both reflection flags set, poly 0x8005, init_val 0xFFFF, xor_out 0xFFFF, and `done` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| setup_en | input | 1 | High while configuration nibbles are presented |
| nib_in | input | 4 | Configuration nibble, MSB on bit 3 |
| width_code | output | 6 | CRC width minus one |
| refl_in | output | 1 | Reflect input bytes flag |
| refl_out | output | 1 | Reflect final result flag |
| poly | output | MAX_WIDTH | Generator polynomial |
| init_val | output | MAX_WIDTH | Starting register value |
| xor_out | output | MAX_WIDTH | Final XOR value |
| done | output | 1 | Configuration complete |

## Verification
Two functions can act in the same cycle: the start of a new sequence, which clears the registers, and the hold that keeps a finished configuration unchanged. The bench provokes this by feeding extra nibbles after `done` and then reopening `setup_en` after a one-cycle gap. The first new nibble must clear every field and `done` on that same edge while still landing in the width code. The bench also drops `setup_en` partway through a field, so that a restart collides with a half-written register. It checks that no nibble left over from the abandoned stream survives.

// File: rtl/crcl_pkg.sv
package crcl_pkg;
   localparam int CODE_W = 6;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HDR1,
      PH_POLY,
      PH_INIT,
      PH_XOR,
      PH_DONE
   } crcl_phase_e;

   localparam int FLD_POLY = 0;
   localparam int FLD_INIT = 1;
   localparam int FLD_XOR  = 2;
   localparam int NUM_FLD  = 3;
endpackage

// File: rtl/crcl_hdr.sv
module crcl_hdr
   import crcl_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_first,
   input  logic              wr_second,
   input  logic [3:0]        nib,
   output logic [CODE_W-1:0] code,
   output logic              refl_out,
   output logic              refl_in
);
   always_ff @(posedge clk) begin
      if (rst) begin
         code     <= '0;
         refl_out <= 1'b0;
         refl_in  <= 1'b0;
      end else if (wr_first) begin
         code     <= {2'b00, nib};
         refl_out <= 1'b0;
         refl_in  <= 1'b0;
      end else if (wr_second) begin
         code[5:4] <= nib[3:2];
         refl_out  <= nib[1];
         refl_in   <= nib[0];
      end
   end

   // R3: header only moves on its two write strobes
   assert_hdr_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!wr_first && !wr_second) |=> ($stable(code) && $stable(refl_out) && $stable(refl_in)));

   assert_hdr_low_R2: assert property (@(posedge clk) disable iff (rst)
      wr_first |=> (code[5:4] == 2'b00 && !refl_out && !refl_in));
endmodule

// File: rtl/crcl_seq.sv
module crcl_seq
   import crcl_pkg::*;
#(
   parameter int MAX_NIB = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               setup_en,
   input  logic [CODE_W-1:0]  code,
   output logic               start,
   output logic               wr_second,
   output logic [NUM_FLD-1:0] wr_fld,
   output logic [IDX_W-1:0]   idx,
   output logic               done
);
   localparam int CNT_W = CODE_W + 1;

   crcl_phase_e      phase;
   logic             setup_q;
   logic             consume;
   logic [CNT_W-1:0] raw_len;
   logic [CNT_W-1:0] nlen;
   logic             last;

   assign raw_len = ({1'b0, code} + CNT_W'(4)) >> 2;
   assign nlen    = (raw_len > CNT_W'(MAX_NIB)) ? CNT_W'(MAX_NIB) : raw_len;
   assign last    = (CNT_W'(idx) == (nlen - CNT_W'(1)));

   assign start     = setup_en && !setup_q;
   assign consume   = setup_en && !start;
   assign wr_second = consume && (phase == PH_HDR1);
   assign wr_fld[FLD_POLY] = consume && (phase == PH_POLY);
   assign wr_fld[FLD_INIT] = consume && (phase == PH_INIT);
   assign wr_fld[FLD_XOR]  = consume && (phase == PH_XOR);

   always_ff @(posedge clk) begin
      if (rst) begin
         setup_q <= 1'b0;
         phase   <= PH_IDLE;
         idx     <= '0;
         done    <= 1'b0;
      end else begin
         setup_q <= setup_en;
         if (start) begin
            phase <= PH_HDR1;
            idx   <= '0;
            done  <= 1'b0;
         end else if (setup_en) begin
            case (phase)
               PH_HDR1: begin
                  phase <= PH_POLY;
                  idx   <= '0;
               end
               PH_POLY: begin
                  if (last) begin
                     phase <= PH_INIT;
                     idx   <= '0;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
               PH_INIT: begin
                  if (last) begin
                     phase <= PH_XOR;
                     idx   <= '0;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
               PH_XOR: begin
                  if (last) begin
                     phase <= PH_DONE;
                     idx   <= '0;
                     done  <= 1'b1;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (rst)
      (phase inside {PH_POLY, PH_INIT, PH_XOR}) |-> (CNT_W'(idx) < nlen));

   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done);

   assert_done_entry_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> ($past(phase) == PH_XOR && $past(setup_en)));

   assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (rst)
      start |=> (!done && phase == PH_HDR1));

   assert_one_write_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0({start, wr_second, wr_fld}));
endmodule

// File: rtl/crcl_field.sv
module crcl_field #(
   parameter int W     = 32,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [3:0]       nib,
   output logic [W-1:0]     value
);
   localparam int NIB = W / 4;

   for (genvar k = 0; k < NIB; k++) begin : g_slot
      logic [3:0] slot_q;
      always_ff @(posedge clk) begin
         if (rst || clr) begin
            slot_q <= '0;
         end else if (we && (idx == IDX_W'(k))) begin
            slot_q <= nib;
         end
      end
      assign value[4*k +: 4] = slot_q;
   end

   assert_field_clear_R2: assert property (@(posedge clk) disable iff (rst)
      clr |=> (value == '0));

   assert_field_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (!clr && !we) |=> $stable(value));

   assert_field_one_slot_R5: assert property (@(posedge clk) disable iff (rst)
      (!clr && we) |=> ($countones(value ^ $past(value)) <= 4));
endmodule

// File: rtl/crc_cfg_loader.sv
module crc_cfg_loader
   import crcl_pkg::*;
#(
   parameter int MAX_WIDTH = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 setup_en,
   input  logic [3:0]           nib_in,
   output logic [5:0]           width_code,
   output logic                 refl_in,
   output logic                 refl_out,
   output logic [MAX_WIDTH-1:0] poly,
   output logic [MAX_WIDTH-1:0] init_val,
   output logic [MAX_WIDTH-1:0] xor_out,
   output logic                 done
);
   localparam int MAX_NIB = MAX_WIDTH / 4;
   localparam int IDX_W   = (MAX_NIB > 1) ? $clog2(MAX_NIB) : 1;

   if ((MAX_WIDTH % 4) != 0 || MAX_WIDTH < 4 || MAX_WIDTH > 64) begin : g_bad_width
      $error("crc_cfg_loader: MAX_WIDTH must be a multiple of 4 within 4..64");
   end

   logic               start;
   logic               wr_second;
   logic [NUM_FLD-1:0] wr_fld;
   logic [IDX_W-1:0]   idx;
   logic [MAX_WIDTH-1:0] fld_val [NUM_FLD];

   crcl_seq #(
      .MAX_NIB (MAX_NIB),
      .IDX_W   (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .setup_en  (setup_en),
      .code      (width_code),
      .start     (start),
      .wr_second (wr_second),
      .wr_fld    (wr_fld),
      .idx       (idx),
      .done      (done)
   );

   crcl_hdr u_hdr (
      .clk       (clk),
      .rst       (rst),
      .wr_first  (start),
      .wr_second (wr_second),
      .nib       (nib_in),
      .code      (width_code),
      .refl_out  (refl_out),
      .refl_in   (refl_in)
   );

   for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
      crcl_field #(
         .W     (MAX_WIDTH),
         .IDX_W (IDX_W)
      ) u_fld (
         .clk   (clk),
         .rst   (rst),
         .clr   (start),
         .we    (wr_fld[f]),
         .idx   (idx),
         .nib   (nib_in),
         .value (fld_val[f])
      );
   end

   assign poly     = fld_val[FLD_POLY];
   assign init_val = fld_val[FLD_INIT];
   assign xor_out  = fld_val[FLD_XOR];

   assert_ignore_after_done_R7: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> ($stable(poly) && $stable(init_val) && $stable(xor_out)
                            && $stable(width_code) && $stable(refl_in) && $stable(refl_out)));

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (!done && poly == '0 && init_val == '0 && xor_out == '0 && width_code == '0));
endmodule

// File: tb/sim_crc_cfg_loader.sv
module sim_crc_cfg_loader;
   localparam int CLK_PERIOD = 10;
   localparam int MW = 32;
   localparam int MAX_NIB = MW / 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          setup_en = 1'b0;
   logic [3:0]    nib_in = 4'h0;
   logic [5:0]    width_code;
   logic          refl_in, refl_out;
   logic [MW-1:0] poly, init_val, xor_out;
   logic          done;

   int tests = 0;
   int fails = 0;
   bit reported = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc_cfg_loader #(.MAX_WIDTH(MW)) u0 (
      .clk(clk), .rst(rst), .setup_en(setup_en), .nib_in(nib_in),
      .width_code(width_code), .refl_in(refl_in), .refl_out(refl_out),
      .poly(poly), .init_val(init_val), .xor_out(xor_out), .done(done)
   );

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int ncount(input int code);
      int r = (code + 4) / 4;
      return (r > MAX_NIB) ? MAX_NIB : r;
   endfunction

   function automatic logic [MW-1:0] msk(input int n);
      if (n >= MAX_NIB) return '1;
      return (MW'(1) << (4 * n)) - MW'(1);
   endfunction

   // drive one nibble at the falling edge; optionally confirm done is still low
   task automatic send(input logic [3:0] v, input bit chk_done);
      @(negedge clk);
      if (chk_done) chk(done == 1'b0, "R6 done low mid-stream", 64'(done), 64'd0);
      setup_en = 1'b1;
      nib_in   = v;
   endtask

   task automatic send_fields(input logic [MW-1:0] p, input logic [MW-1:0] i,
                              input logic [MW-1:0] x, input int n);
      for (int k = 0; k < n; k++) send(p[4*k +: 4], 1);
      for (int k = 0; k < n; k++) send(i[4*k +: 4], 1);
      for (int k = 0; k < n; k++) send(x[4*k +: 4], 1);
   endtask

   task automatic load(input logic [5:0] code, input logic ro, input logic ri,
                       input logic [MW-1:0] p, input logic [MW-1:0] i, input logic [MW-1:0] x);
      send(code[3:0], 0);
      send({code[5:4], ro, ri}, 1);
      send_fields(p, i, x, ncount(int'(code)));
   endtask

   task automatic check_cfg(input logic [5:0] code, input logic ro, input logic ri,
                            input logic [MW-1:0] p, input logic [MW-1:0] i, input logic [MW-1:0] x);
      logic [MW-1:0] m = msk(ncount(int'(code)));
      chk(width_code == code, "R2/R3 width code", 64'(width_code), 64'(code));
      chk(refl_out == ro, "R3 refl_out", 64'(refl_out), 64'(ro));
      chk(refl_in == ri, "R3 refl_in", 64'(refl_in), 64'(ri));
      chk(poly == (p & m), "R4/R5 poly", 64'(poly), 64'(p & m));
      chk(init_val == (i & m), "R4/R5 init_val", 64'(init_val), 64'(i & m));
      chk(xor_out == (x & m), "R4/R5 xor_out", 64'(xor_out), 64'(x & m));
      chk(done == 1'b1, "R6 done after last nibble", 64'(done), 64'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      logic [MW-1:0] p, i, x;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 0 && width_code == 0 && !refl_in && !refl_out, "R1 reset ctrl",
          64'({done, width_code, refl_in, refl_out}), 64'd0);
      chk(poly == 0 && init_val == 0 && xor_out == 0, "R1 reset fields",
          64'(poly | init_val | xor_out), 64'd0);
      rst = 1'b0;

      // R4 R5 R6: sweep every width code
      for (int c = 0; c < 64; c++) begin
         p = 32'hA5C3_1E69 ^ (32'(c) * 32'h0101_0101);
         i = 32'h3D7B_92E4 + 32'(c) * 32'h0011_2233;
         x = ~p ^ 32'h5A5A_0F0F;
         load(6'(c), c[0], ~c[1], p, i, x);
         @(negedge clk);
         check_cfg(6'(c), c[0], ~c[1], p, i, x);
         setup_en = 1'b0;
         @(negedge clk);
         check_cfg(6'(c), c[0], ~c[1], p, i, x);
      end

      // R9 known stream
      load(6'd15, 1'b1, 1'b1, 32'h8005, 32'hFFFF, 32'hFFFF);
      @(negedge clk);
      chk(width_code == 15 && refl_in && refl_out, "R9 header", 64'({width_code, refl_out, refl_in}), 64'h3F);
      chk(poly == 32'h8005, "R9 poly", 64'(poly), 64'h8005);
      chk(init_val == 32'hFFFF && xor_out == 32'hFFFF, "R9 init/xor", 64'({init_val, xor_out}), 64'h0000FFFF0000FFFF);
      chk(done == 1, "R9 done", 64'(done), 64'd1);

      // R7: extra nibbles after done are ignored
      setup_en = 1'b1;
      nib_in = 4'hA;
      repeat (6) @(negedge clk);
      chk(poly == 32'h8005 && init_val == 32'hFFFF && xor_out == 32'hFFFF, "R7 fields held",
          64'(poly ^ init_val ^ xor_out), 64'(32'h8005 ^ 32'hFFFF ^ 32'hFFFF));
      chk(width_code == 15 && done, "R7 header/done held", 64'({done, width_code}), 64'h4F);

      // R2 R8: one-cycle gap then restart, collides with held config
      setup_en = 1'b0;
      send(4'h3, 0);
      @(negedge clk);
      chk(poly == 0 && init_val == 0 && xor_out == 0, "R2 fields cleared on start",
          64'(poly | init_val | xor_out), 64'd0);
      chk(width_code == 3 && !refl_in && !refl_out, "R2 first nibble to width", 64'({width_code, refl_out, refl_in}), 64'(6'd3 << 2));
      chk(done == 0, "R2 done cleared on start", 64'(done), 64'd0);
      setup_en = 1'b0;

      // R8: abandon a stream mid-field, then a fresh one
      send(4'hF, 0); send(4'h3, 1); send(4'h5, 1); send(4'h7, 1);
      @(negedge clk);
      setup_en = 1'b0;
      send(4'h2, 0);
      @(negedge clk);
      chk(poly == 0 && width_code == 2, "R8 restart after gap", 64'({poly, 2'b00, width_code}), 64'd2);
      setup_en = 1'b1;
      nib_in = 4'b0101;   // code 0x12, refl_out=0, refl_in=1
      send_fields(32'h0009_8765, 32'h0004_3210, 32'h000F_EDCB, 5);
      @(negedge clk);
      check_cfg(6'h12, 1'b0, 1'b1, 32'h0009_8765, 32'h0004_3210, 32'h000F_EDCB);
      setup_en = 1'b0;

      // R1: reset from a loaded state
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(done == 0 && poly == 0 && width_code == 0 && xor_out == 0, "R1 reset after load",
          64'({done, width_code} | 64'(poly | xor_out)), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      report();
   end
endmodule